// File: doc/BRIEF.md
# Lockable Flash Timing Clock Divider

This block holds an 8-bit control word that sets up a programmable divider. The divider turns the bus clock into the slow timing tick that paces flash program and erase sequencing. Software writes the word through a simple strobe-and-data port and can read it back at any time. The tick leaves the block as a one-cycle enable pulse, not as a derived clock.

The top bit of each accepted write decides whether the word stays open for further writes. A 0 there freezes the word until the next reset. On read-back, the top bit instead reports whether any write has landed since reset. Bit 6 puts a fixed divide-by-8 prescaler ahead of a 6-bit divide counter held in bits 5:0. The overall ratio is (bits 5:0 + 1), multiplied by 8 when the prescaler is on. That gives 2 at minimum and 512 at maximum. Software is expected to choose a ratio that puts the tick between 150 kHz and 200 kHz.

Top module: `flash_tick_div`

## Requirements
- R1: After reset, rd_data_o reads 0x00, loaded_o is 0 and tick_o is 0.
- R2: An accepted write whose bit 7 is 0 stores bits 6:0. Every later write is then ignored until reset, starting from the next cycle.
- R3: An accepted write whose bit 7 is 1 stores bits 6:0 and leaves the register writable, so the next write is also accepted.
- R4: Bit 7 of rd_data_o, and loaded_o, read 0 until the first accepted write since reset and 1 from then on, whatever value was written into bit 7. Bits 6:0 read back the stored value.
- R5: With bit 6 at 0 and bits 5:0 at D (D>0), tick_o pulses once every D+1 cycles. The minimum period is 2 (D=1).
- R6: With bit 6 at 1 and bits 5:0 at D (D>0), tick_o pulses once every 8*(D+1) cycles. The maximum period is 512 (D=63).
- R7: tick_o is never high for two consecutive cycles.
- R8: tick_o stays 0 while no write has been accepted since reset, and while bits 5:0 hold 0.
- R9: An accepted write that changes bits 6:0 restarts the count. With a new period N, the first tick is high in the N-th cycle after the write's clock edge.
- R10: An accepted write that leaves bits 6:0 unchanged does not disturb the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data: bit 7 keep-open, bit 6 prescale enable, bits 5:0 divide value |
| rd_data_o | output | 8 | Read data: bit 7 written-since-reset flag, bits 6:0 stored value |
| tick_o | output | 1 | One-cycle timing tick enable |
| loaded_o | output | 1 | High once a write has been accepted since reset |

## Verification
The assertions check four things on every cycle. A locked register never changes on a write. The loaded flag only rises on a write cycle and never falls outside reset. The tick never fires while the block is idle. The tick never lasts two cycles. Exact tick periods at both ends of the range, the restart point after a changed write and the unchanged phase after an identical write can only be shown by the bench. It does this with a behavioural model compared on every clock, plus directed period measurements.

// File: rtl/flash_div_pkg.sv
package flash_div_pkg;
  localparam int unsigned DIV_W     = 6;
  localparam int unsigned PRE_RATIO = 8;
  localparam int unsigned REG_W     = DIV_W + 2;

  typedef struct packed {
    logic             pre_en;
    logic [DIV_W-1:0] div_val;
  } div_cfg_t;
endpackage

// File: rtl/fdiv_ctrl_reg.sv
module fdiv_ctrl_reg
  import flash_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output div_cfg_t         cfg_o,
  output logic             loaded_o,
  output logic             locked_o,
  output logic             restart_o
);
  div_cfg_t cfg_q;
  logic     loaded_q, open_q;
  logic     accept;
  div_cfg_t cfg_new;

  assign accept  = wr_en_i && open_q;
  assign cfg_new = div_cfg_t'(wr_data_i[REG_W-2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
      open_q   <= 1'b1;
    end else if (accept) begin
      cfg_q    <= cfg_new;
      loaded_q <= 1'b1;
      open_q   <= wr_data_i[REG_W-1];
    end
  end

  assign cfg_o     = cfg_q;
  assign loaded_o  = loaded_q;
  assign locked_o  = !open_q;
  assign restart_o = accept && (cfg_new != cfg_q);
endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic pre_en_i,
  output logic step_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !pre_en_i) cnt_q <= '0;
    else if (cnt_q == LAST)      cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // bypassed prescaler steps every cycle
  assign step_o = pre_en_i ? (cnt_q == LAST) : 1'b1;
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && step_i && at_end;
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div
  import flash_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_o,
  output logic             loaded_o
);
  div_cfg_t cfg;
  logic     loaded, locked, restart;
  logic     run, clear, pre_step;

  fdiv_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .loaded_o  (loaded),
    .locked_o  (locked),
    .restart_o (restart)
  );

  assign run   = loaded && (cfg.div_val != '0);
  assign clear = restart || !run;

  fdiv_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .pre_en_i (cfg.pre_en),
    .step_o   (pre_step)
  );

  fdiv_counter #(.W(DIV_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .step_i  (pre_step),
    .limit_i (cfg.div_val),
    .tick_o  (tick_o)
  );

  assign rd_data_o = {loaded, cfg};
  assign loaded_o  = loaded;
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
  import flash_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             tick_o,
  input logic             loaded_o,
  input logic             locked
);
  assert_lock_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_en_i) |=> $stable(rd_data_o));

  assert_loaded_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_o) |-> $past(wr_en_i));

  assert_loaded_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |=> loaded_o);

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (loaded_o && (rd_data_o[DIV_W-1:0] != '0)));
endmodule

bind flash_tick_div fdiv_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .tick_o    (tick_o),
  .loaded_o  (loaded_o),
  .locked    (locked)
);

// File: tb/tb_flash_tick_div.sv
module tb_flash_tick_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       tick_o, loaded_o;

  int tests = 0, fails = 0;
  int cyc = 0;

  // reference model state
  bit       m_loaded = 0, m_open = 1;
  bit [6:0] m_cfg = '0;
  int       m_phase = 0;
  bit       m_tick;
  bit       cmp_on = 0;

  always #10 clk_i = ~clk_i;

  flash_tick_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .tick_o(tick_o), .loaded_o(loaded_o)
  );

  function automatic int period(bit [6:0] c);
    return (int'(c[5:0]) + 1) * (c[6] ? 8 : 1);
  endfunction

  function automatic bit active();
    return m_loaded && (m_cfg[5:0] != 0);
  endfunction

  always_comb m_tick = active() && (m_phase == period(m_cfg) - 1);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_loaded = 0; m_open = 1; m_cfg = '0; m_phase = 0;
    end else begin
      bit restart;
      bit act;
      act = active();
      restart = wr_en_i && m_open && (wr_data_i[6:0] != m_cfg);
      if (restart || !act) m_phase = 0;
      else m_phase = (m_phase + 1) % period(m_cfg);
      if (wr_en_i && m_open) begin
        m_cfg = wr_data_i[6:0]; m_loaded = 1; m_open = wr_data_i[7];
      end
      cyc++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      tests++;
      if (tick_o !== m_tick) begin
        fails++;
        $display("FAIL R5 R6 R8 R9 R10 tick at cycle %0d: got %0b exp %0b", cyc, tick_o, m_tick);
      end
      tests++;
      if (rd_data_o !== {m_loaded, m_cfg} || loaded_o !== m_loaded) begin
        fails++;
        $display("FAIL R2 R3 R4 readback: got %02h/%0b exp %02h/%0b",
                 rd_data_o, loaded_o, {m_loaded, m_cfg}, m_loaded);
      end
    end
  end

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic write(bit [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // cycles between two consecutive ticks, -1 on timeout
  task automatic measure(output int p);
    int k;
    p = -1;
    k = 0;
    while (tick_o !== 1'b1 && k < 2000) begin @(negedge clk_i); k++; end
    if (k < 2000) begin
      @(negedge clk_i);
      k = 1;
      while (tick_o !== 1'b1 && k < 2000) begin @(negedge clk_i); k++; end
      if (k < 2000) p = k;
    end
  endtask

  task automatic count_ticks(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk_i); if (tick_o) c++; end
  endtask

  initial begin
    int p, c;
    idle(2);
    // R1 reset state
    check("R1 rd_data", rd_data_o, 0);
    check("R1 loaded", loaded_o, 0);
    check("R1 tick", tick_o, 0);
    rst_ni = 1;
    cmp_on = 1;
    // R8 unwritten: no ticks
    count_ticks(40, c);
    check("R8 ticks before write", c, 0);
    check("R4 bit7 before write", rd_data_o[7], 0);

    // R3/R5 minimum ratio, writable
    write(8'h81);
    check("R4 bit7 after write", rd_data_o[7], 1);
    check("R3 readback 0x81", rd_data_o, 8'h81);
    measure(p);
    check("R5 period min", p, 2);

    // R8 divide value 0
    write(8'h80);
    count_ticks(60, c);
    check("R8 ticks with div 0", c, 0);

    // R6 maximum ratio
    write(8'hFF);
    measure(p);
    check("R6 period max", p, 512);
    idle(100);
    write(8'hFF);          // R10 same value mid-period, model checks phase
    measure(p);
    check("R10 period after same write", p, 512);

    // R2 lock with bit7=0, R4 reads 1
    write(8'h45);
    check("R4 bit7 reads 1 after 0 written", rd_data_o[7], 1);
    check("R2 readback 0x45", rd_data_o[6:0], 7'h45);
    measure(p);
    check("R6 period 48", p, 48);
    write(8'hBF);
    check("R2 write ignored", rd_data_o, 8'hC5);
    write(8'h01);
    check("R2 second ignored", rd_data_o, 8'hC5);
    measure(p);
    check("R2 period kept", p, 48);

    // reset clears lock
    @(negedge clk_i); rst_ni = 0;
    idle(2);
    check("R1 reset again", rd_data_o, 0);
    rst_ni = 1;
    write(8'h03);
    check("R2 writable after reset", rd_data_o, 8'h83);
    measure(p);
    check("R5 period 4", p, 4);
    write(8'h05);
    check("R2 locked by 0x03", rd_data_o, 8'h83);
    idle(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule